// File: doc/BRIEF.md
# Exhaustive Bitwise Fitness Evaluator

This block grades a candidate combinational circuit against a reference circuit that implements the intended function. After a start pulse it walks an input counter through every code of an N_IN-bit input space, one code per clock. The plain code drives the reference circuit. A copy of the code, with one bit optionally pinned to a constant, drives the candidate circuit. This pinned bit models a stuck-at defect on a logic-cell input, so the same candidate can be graded as if it were degraded.

One cycle after each code is applied, both N_OUT-bit responses are registered. Every output position where the two responses agree adds one point to a running score. The best possible score is 2^N_IN times N_OUT. When the sweep ends, the block raises a one-cycle done pulse. At that point it shows the final score, a flag that says the score is perfect, and a flag that says the score reached a programmable acceptance level, for example 95 % of perfect. A search engine that builds candidates would use these results to decide whether to stop.

Top module: `fitness_scorer`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `fitness`, `max_reached` and `threshold_met` are all zero.
- R2: A start that is accepted makes `busy` high for exactly 2^N_IN cycles. In the first of these cycles `stim` is 0, and it goes up by one in each later busy cycle, so every input code is applied once, in ascending order.
- R3: The final `fitness` is the number of (code, output bit) pairs for which the candidate output bit equals the reference output bit. It never exceeds 2^N_IN * N_OUT. With N_IN=5 and N_OUT=2 that limit is 64.
- R4: `done` is a single-cycle pulse. If the start is sampled at clock edge 0, `done` and the final results become visible after clock edge 2^N_IN + 1.
- R5: At the done pulse, `max_reached` is 1 exactly when `fitness` equals 2^N_IN * N_OUT.
- R6: At the done pulse, `threshold_met` is 1 exactly when `fitness` is greater than or equal to the `thresh` value sampled with the accepted start. Both flags stay 0 for the whole sweep, so a threshold of 0 is reported only once the sweep has finished.
- R7: When `fault_en` is 1, bit `fault_sel` of `cand_in` equals `fault_val` and all other bits equal `stim`. When `fault_en` is 0, `cand_in` equals `stim`. `stim` itself is never altered by the fault.
- R8: A start pulse is ignored while a sweep is in progress, including the cycle in which the last sample is still being counted. The sweep in progress, its timing and its result are not changed.
- R9: After the done pulse, `fitness`, `max_reached` and `threshold_met` keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a new sweep |
| thresh | input | FIT_W | Acceptance score, sampled on accepted start |
| fault_en | input | 1 | Enable the stuck-at defect on the candidate input |
| fault_sel | input | IDX_W | Index of the candidate input bit that is pinned |
| fault_val | input | 1 | Constant value of the pinned bit |
| stim | output | N_IN | Current input code, drives the reference circuit |
| cand_in | output | N_IN | Input code with the defect applied, drives the candidate |
| cand_out | input | N_OUT | Candidate response |
| ref_out | input | N_OUT | Reference response |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| fitness | output | FIT_W | Score: number of matching output bits |
| max_reached | output | 1 | Score equals the best possible score |
| threshold_met | output | 1 | Score is at least the sampled threshold |

## Verification
The bench grades a perfect candidate, a candidate that disagrees on exactly one bit, a badly wrong candidate, and candidates with the input pinned low or high at different positions. A design that drops the last code, counts mismatches instead of matches, or counts one point per code instead of one per bit would be off by a small, known amount in these cases. Thresholds are set exactly at the score, one above it and at zero. These settings catch a strict comparison used in place of greater-or-equal, and a flag that is set before the sweep ends. The bench also sends a second start in the middle of a sweep and another in the cycle right after `busy` falls. A design that restarted on either would show a longer latency, a wrong score or an extra done pulse.

// File: rtl/fit_pkg.sv
// Shared sizing helpers for the fitness evaluator.
// Assumes n_in is small enough that 2^n_in * n_out fits in 32 bits.
package fit_pkg;
    // Best possible score for a given input/output width.
    function automatic int best_score(input int n_in, input int n_out);
        return (1 << n_in) * n_out;
    endfunction

    // Bits needed to hold a score from 0 up to best_score inclusive.
    function automatic int score_bits(input int n_in, input int n_out);
        return $clog2(best_score(n_in, n_out) + 1);
    endfunction
endpackage

// File: rtl/vec_sequencer.sv
// Input-code sequencer: walks every N_IN-bit code once, in ascending order,
// after a launch pulse, and applies the optional stuck-at defect to the copy
// that goes to the candidate. Assumes launch is only given while idle.
module vec_sequencer #(
    parameter int N_IN  = 5,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             fault_en,
    input  logic [IDX_W-1:0] fault_sel,
    input  logic             fault_val,
    output logic [N_IN-1:0]  code,
    output logic [N_IN-1:0]  code_faulty,
    output logic             running,
    output logic             final_code
);
    localparam logic [N_IN-1:0] LAST_CODE = '1;

    logic [N_IN-1:0] code_q;
    logic            run_q;

    assign final_code = run_q && (code_q == LAST_CODE);

    // Step the code counter and the running flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            run_q  <= 1'b0;
        end else if (launch) begin
            code_q <= '0;
            run_q  <= 1'b1;
        end else if (run_q) begin
            code_q <= code_q + 1'b1;
            if (code_q == LAST_CODE) begin
                run_q <= 1'b0;
            end
        end
    end

    // Pin one candidate input bit when the defect is enabled.
    for (genvar i = 0; i < N_IN; i++) begin : g_pin
        assign code_faulty[i] = (fault_en && (fault_sel == IDX_W'(i))) ? fault_val : code_q[i];
    end

    assign code    = code_q;
    assign running = run_q;
endmodule

// File: rtl/match_counter.sv
// Counts output positions where candidate and reference agree.
// Purely combinational; assumes both buses are already registered.
module match_counter #(
    parameter int N_OUT = 2,
    parameter int CNT_W = 2
) (
    input  logic [N_OUT-1:0] cand,
    input  logic [N_OUT-1:0] refv,
    output logic [CNT_W-1:0] hits
);
    logic [N_OUT-1:0] agree;

    assign agree = ~(cand ^ refv);

    // Add up the agreeing positions.
    always_comb begin
        hits = '0;
        for (int j = 0; j < N_OUT; j++) begin
            hits = hits + CNT_W'(agree[j]);
        end
    end
endmodule

// File: rtl/score_accum.sv
// Sample stage and score accumulator. Registers both responses one cycle
// after each code, adds the agreement count, and on the final sample raises
// done together with the perfect-score and threshold flags.
// Assumes clear is only given while no sample is in flight.
module score_accum #(
    parameter int N_OUT = 2,
    parameter int FIT_W = 7,
    parameter int CNT_W = 2,
    parameter int BEST  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [FIT_W-1:0] thresh,
    input  logic             code_valid,
    input  logic             code_final,
    input  logic [N_OUT-1:0] cand_out,
    input  logic [N_OUT-1:0] ref_out,
    output logic             sample_valid,
    output logic [FIT_W-1:0] thr_held,
    output logic [FIT_W-1:0] score,
    output logic             done,
    output logic             perfect,
    output logic             passed
);
    localparam logic [FIT_W-1:0] BEST_V = FIT_W'(BEST);

    logic [N_OUT-1:0] cand_q;
    logic [N_OUT-1:0] ref_q;
    logic             vld_q;
    logic             last_q;
    logic [CNT_W-1:0] hits;
    logic [FIT_W-1:0] score_q;
    logic [FIT_W-1:0] score_nxt;
    logic [FIT_W-1:0] thr_q;

    // Capture both responses one cycle after the code is applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '0;
            ref_q  <= '0;
            vld_q  <= 1'b0;
            last_q <= 1'b0;
        end else begin
            cand_q <= cand_out;
            ref_q  <= ref_out;
            vld_q  <= code_valid;
            last_q <= code_final;
        end
    end

    match_counter #(
        .N_OUT (N_OUT),
        .CNT_W (CNT_W)
    ) u_match (
        .cand (cand_q),
        .refv (ref_q),
        .hits (hits)
    );

    assign score_nxt = score_q + FIT_W'(hits);

    // Accumulate the score and produce the end-of-sweep results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            score_q <= '0;
            thr_q   <= '0;
            done    <= 1'b0;
            perfect <= 1'b0;
            passed  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clear) begin
                score_q <= '0;
                thr_q   <= thresh;
                perfect <= 1'b0;
                passed  <= 1'b0;
            end else if (vld_q) begin
                score_q <= score_nxt;
                if (last_q) begin
                    done    <= 1'b1;
                    perfect <= (score_nxt == BEST_V);
                    passed  <= (score_nxt >= thr_q);
                end
            end
        end
    end

    assign sample_valid = vld_q;
    assign thr_held     = thr_q;
    assign score        = score_q;
endmodule

// File: rtl/fitness_scorer.sv
// Top of the exhaustive bitwise fitness evaluator. Accepts a start only when
// no sweep and no sample are in flight, sequences all input codes, scores
// agreement bit by bit and reports the result with a done pulse.
// Assumes candidate and reference are combinational with respect to their
// inputs, so their responses are valid within the same cycle.
module fitness_scorer #(
    parameter int N_IN  = 5,
    parameter int N_OUT = 2,
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int FIT_W = fit_pkg::score_bits(N_IN, N_OUT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FIT_W-1:0] thresh,
    input  logic             fault_en,
    input  logic [IDX_W-1:0] fault_sel,
    input  logic             fault_val,
    output logic [N_IN-1:0]  stim,
    output logic [N_IN-1:0]  cand_in,
    input  logic [N_OUT-1:0] cand_out,
    input  logic [N_OUT-1:0] ref_out,
    output logic             busy,
    output logic             done,
    output logic [FIT_W-1:0] fitness,
    output logic             max_reached,
    output logic             threshold_met
);
    localparam int BEST  = fit_pkg::best_score(N_IN, N_OUT);
    localparam int CNT_W = $clog2(N_OUT + 1);

    logic launch;
    logic running;
    logic final_code;
    logic sample_valid;
    logic [FIT_W-1:0] thr_held;

    // Accept a start only when the whole pipeline is empty.
    assign launch = start && !running && !sample_valid;

    vec_sequencer #(
        .N_IN  (N_IN),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .fault_en    (fault_en),
        .fault_sel   (fault_sel),
        .fault_val   (fault_val),
        .code        (stim),
        .code_faulty (cand_in),
        .running     (running),
        .final_code  (final_code)
    );

    score_accum #(
        .N_OUT (N_OUT),
        .FIT_W (FIT_W),
        .CNT_W (CNT_W),
        .BEST  (BEST)
    ) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (launch),
        .thresh       (thresh),
        .code_valid   (running),
        .code_final   (final_code),
        .cand_out     (cand_out),
        .ref_out      (ref_out),
        .sample_valid (sample_valid),
        .thr_held     (thr_held),
        .score        (fitness),
        .done         (done),
        .perfect      (max_reached),
        .passed       (threshold_met)
    );

    assign busy = running;
endmodule

// File: rtl/fitness_scorer_chk.sv
// Assertion checker for fitness_scorer, attached with bind below.
module fitness_scorer_chk #(
    parameter int N_IN  = 5,
    parameter int N_OUT = 2,
    parameter int IDX_W = 3,
    parameter int FIT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             sample_valid,
    input logic [N_IN-1:0]  stim,
    input logic [N_IN-1:0]  cand_in,
    input logic             fault_en,
    input logic [FIT_W-1:0] fitness,
    input logic [FIT_W-1:0] thr_held,
    input logic             max_reached,
    input logic             threshold_met
);
    localparam logic [FIT_W-1:0] BEST_V = FIT_W'(fit_pkg::best_score(N_IN, N_OUT));

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!busy && !done && fitness == '0 && !max_reached && !threshold_met)); // R1
    AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> (stim == $past(stim) + 1'b1)); // R2
    AST_CODE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (stim == '0)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fitness <= BEST_V); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
    AST_MAX_FLAG: assert property (@(posedge clk) disable iff (!rst_n) done |-> (max_reached == (fitness == BEST_V))); // R5
    AST_THR_FLAG: assert property (@(posedge clk) disable iff (!rst_n) done |-> (threshold_met == (fitness >= thr_held))); // R6
    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (!max_reached && !threshold_met)); // R6
    AST_NO_FAULT_PASS: assert property (@(posedge clk) disable iff (!rst_n) !fault_en |-> (cand_in == stim)); // R7
    AST_FAULT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n) fault_en |-> ($countones(cand_in ^ stim) <= 1)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && $past(busy)) |=> (!busy || stim != '0)); // R8
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !sample_valid && !start) |=> ($stable(fitness) && $stable(max_reached) && $stable(threshold_met))); // R9
endmodule

bind fitness_scorer fitness_scorer_chk #(
    .N_IN  (N_IN),
    .N_OUT (N_OUT),
    .IDX_W (IDX_W),
    .FIT_W (FIT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .sample_valid  (sample_valid),
    .stim          (stim),
    .cand_in       (cand_in),
    .fault_en      (fault_en),
    .fitness       (fitness),
    .thr_held      (thr_held),
    .max_reached   (max_reached),
    .threshold_met (threshold_met)
);

// File: tb/test_fitness_scorer.sv
// Scoreboard bench: the driver task computes the expected result of a sweep
// and queues it; the monitor checks every applied code and pops the queue on done.
module test_fitness_scorer;
    localparam int NI    = 5;
    localparam int NO    = 2;
    localparam int IW    = 3;
    localparam int FW    = 7;
    localparam int BEST  = 64;
    localparam int NVEC  = 1 << NI;

    typedef struct {
        int fit;
        bit mx;
        bit th;
        int t0;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [FW-1:0] thresh = '0;
    logic          fault_en = 1'b0;
    logic [IW-1:0] fault_sel = '0;
    logic          fault_val = 1'b0;
    logic [NI-1:0] stim;
    logic [NI-1:0] cand_in;
    logic [NO-1:0] cand_out;
    logic [NO-1:0] ref_out;
    logic          busy;
    logic          done;
    logic [FW-1:0] fitness;
    logic          max_reached;
    logic          threshold_met;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   bug = 0;
    int   dones = 0;
    int   pushes = 0;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fitness_scorer #(.N_IN(NI), .N_OUT(NO)) i_fitness_scorer (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .thresh        (thresh),
        .fault_en      (fault_en),
        .fault_sel     (fault_sel),
        .fault_val     (fault_val),
        .stim          (stim),
        .cand_in       (cand_in),
        .cand_out      (cand_out),
        .ref_out       (ref_out),
        .busy          (busy),
        .done          (done),
        .fitness       (fitness),
        .max_reached   (max_reached),
        .threshold_met (threshold_met)
    );

    // Reference function: bit 0 is the parity, bit 1 is (x0 & x1) | x4.
    function automatic logic [NO-1:0] ref_fn(input logic [NI-1:0] x);
        return {(x[0] & x[1]) | x[4], ^x};
    endfunction

    // Candidate: reference with a selectable defect.
    function automatic logic [NO-1:0] cand_fn(input logic [NI-1:0] x, input int b);
        logic [NO-1:0] r;
        r = ref_fn(x);
        if (b == 1 && x[2]) r[0] = ~r[0];
        if (b == 2 && x == NI'(7)) r[1] = ~r[1];
        return r;
    endfunction

    function automatic logic [NI-1:0] pin(input logic [NI-1:0] x, input bit en,
                                          input int idx, input bit v);
        logic [NI-1:0] y;
        y = x;
        if (en) y[idx] = v;
        return y;
    endfunction

    assign ref_out  = ref_fn(stim);
    assign cand_out = cand_fn(cand_in, bug);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
        end
    endtask

    // Driver: set up, compute expectation, push, start, optionally poke start again.
    task automatic run(input int b, input bit fen, input int fidx, input bit fv,
                       input int thr, input int extra);
        exp_t e;
        int f;
        f = 0;
        for (int x = 0; x < NVEC; x++) begin
            logic [NO-1:0] c;
            logic [NO-1:0] r;
            r = ref_fn(NI'(x));
            c = cand_fn(pin(NI'(x), fen, fidx, fv), b);
            for (int j = 0; j < NO; j++) if (c[j] == r[j]) f++;
        end
        @(negedge clk);
        bug = b; fault_en = fen; fault_sel = IW'(fidx); fault_val = fv; thresh = FW'(thr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e.fit = f; e.mx = (f == BEST); e.th = (f >= thr); e.t0 = cyc;
        sb.push_back(e);
        pushes++;
        // Change threshold mid-sweep: must not matter (sampled at start).
        thresh = FW'(BEST);
        if (extra == 1) begin
            repeat (10) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end else if (extra == 2) begin
            while (busy) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: per-code checks and result comparison on done.
    int  idx = 0;
    bit  pbusy = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                if (!pbusy) idx = 0;
                check(stim == NI'(idx), "R2 code order", int'(stim), idx);
                check(cand_in == pin(NI'(idx), fault_en, int'(fault_sel), fault_val),
                      "R7 pinned input", int'(cand_in), int'(pin(NI'(idx), fault_en, int'(fault_sel), fault_val)));
                check(!max_reached && !threshold_met, "R6 flags quiet in sweep",
                      int'({max_reached, threshold_met}), 0);
                idx++;
            end
            if (done) begin
                dones++;
                if (sb.size() == 0) begin
                    check(1'b0, "R8 unexpected done", dones, pushes);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(idx == NVEC, "R2 code count", idx, NVEC);
                    check(int'(fitness) == e.fit, "R3 fitness", int'(fitness), e.fit);
                    check(cyc - e.t0 == NVEC + 1, "R4 latency", cyc - e.t0, NVEC + 1);
                    check(max_reached == e.mx, "R5 max flag", int'(max_reached), int'(e.mx));
                    check(threshold_met == e.th, "R6 threshold flag", int'(threshold_met), int'(e.th));
                end
            end
            pbusy = busy;
        end
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 reset busy/done", int'({busy, done}), 0);
        check(fitness == '0, "R1 reset fitness", int'(fitness), 0);
        check(!max_reached && !threshold_met, "R1 reset flags", int'({max_reached, threshold_met}), 0);

        run(0, 1'b0, 0, 1'b0, BEST, 0);     // perfect candidate
        run(2, 1'b0, 0, 1'b0, BEST, 0);     // one bit wrong, threshold one above score
        run(2, 1'b0, 0, 1'b0, BEST - 1, 0); // threshold exactly at score
        run(1, 1'b0, 0, 1'b0, 0, 0);        // bad candidate, threshold zero
        run(0, 1'b1, 2, 1'b0, 61, 0);       // stuck-at-0, 95 % level
        run(0, 1'b1, 4, 1'b1, 40, 0);       // stuck-at-1 on top bit
        run(0, 1'b1, 0, 1'b1, 10, 1);       // R8: start mid-sweep
        run(2, 1'b0, 0, 1'b0, 5, 2);        // R8: start while last sample in flight

        // R9: results hold after done
        held = int'(fitness);
        repeat (20) @(negedge clk);
        check(int'(fitness) == held, "R9 fitness held", int'(fitness), held);
        check(max_reached == 1'b0 && threshold_met == 1'b1, "R9 flags held",
              int'({max_reached, threshold_met}), 1);
        check(dones == pushes, "R8 done count", dones, pushes);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule